// File: doc/BRIEF.md
# Instruction-Interleaved Context Scheduler

This block is the thread-select front end of a barrel-style multithreaded pipeline. Several architectural processor contexts share one pipeline. The block keeps a small state record and a program counter for each context. On every clock it picks one context to issue and puts that context's ID and PC on the issue port. The choice follows a rotation over the context IDs. A context cannot be picked again until the pipeline depth has passed since it last issued. Because of this, two instructions from the same context are never in flight together, and the pipeline behind the block needs no interlock and no operand forwarding.

The back end reports three kinds of event. A context that takes a long-latency event, such as a cache miss, is parked as waiting and keeps its restart PC. A context that reaches an instruction the hardware does not implement is parked as transplanted. It is then offered, one at a time, to an external software helper over a valid/ready handoff port. A context that stops is parked as halted. The other contexts keep issuing while any context is parked. A context returns to the rotation when its miss completes, or when the helper hands it back with a resume PC.

Top module: `ctx_sched`

## Requirements
- R1: After reset every context is ready (state code 2'b00), context i holds PC BOOT_PC + i*BOOT_STRIDE (0x1000 + i*0x100 by default), iss_valid and hoff_valid are low, and ctx_state shows context i in bits [2i+1:2i].
- R2: The issue registers update one cycle after the state they read. The search for the next context starts at the ID after the last issued ID, wraps modulo NCTX, and takes the first eligible context. Eligible means ready and past its spacing window. Each issue advances that context's PC by 4.
- R3: A context is never issued again within DEPTH (14) cycles of its previous issue, so two consecutive issues always carry different IDs. When no context is eligible, iss_valid is low for that cycle.
- R4: A miss event for a ready context sets it to waiting (2'b01) with PC = miss_pc on the next cycle. The context is not issued while it waits.
- R5: A fill event for a waiting context makes it ready (2'b00) on the next cycle. A fill for a context in any other state is ignored.
- R6: An unimplemented-instruction event for a ready context sets it to transplanted (2'b10) with PC = unimp_pc. While the helper is idle, the lowest-ID transplanted context is loaded into the offer on the next cycle. hoff_ctx and hoff_pc stay stable while hoff_valid is high until hoff_ready is seen.
- R7: Only one transplant is outstanding at a time. After the offer is accepted, no new offer appears until a return arrives with hret_ctx equal to the accepted ID. That return makes the context ready with PC = hret_pc. A return with any other ID is ignored.
- R8: A halt event for a ready context sets it to halted (2'b11). It stays halted until reset, and fill and return events do not change it.
- R9: Miss, unimplemented-instruction and halt events act only on ready contexts. When several of these hit the same context in one cycle, halt wins over unimplemented, and unimplemented wins over miss. A PC written by an event overrides the issue increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | output | 1 | An instruction slot is issued this cycle |
| iss_ctx | output | 4 | ID of the issued context |
| iss_pc | output | 32 | PC of the issued context |
| miss_valid | input | 1 | Long-latency event |
| miss_ctx | input | 4 | Context that took the event |
| miss_pc | input | 32 | Restart PC for that context |
| fill_valid | input | 1 | Long-latency event completed |
| fill_ctx | input | 4 | Context whose event completed |
| unimp_valid | input | 1 | Unimplemented instruction reached |
| unimp_ctx | input | 4 | Context that reached it |
| unimp_pc | input | 32 | PC of that instruction |
| halt_valid | input | 1 | Context stops |
| halt_ctx | input | 4 | Context that stops |
| hoff_valid | output | 1 | Transplant offered to the helper |
| hoff_ready | input | 1 | Helper accepts the offer |
| hoff_ctx | output | 4 | Offered context ID |
| hoff_pc | output | 32 | Offered context PC |
| hret_valid | input | 1 | Helper returns a context |
| hret_ctx | input | 4 | Returned context ID |
| hret_pc | input | 32 | PC at which the context resumes |
| ctx_state | output | 32 | Two-bit state code per context |

## Verification
The assertions assume little about the inputs. hoff_ready may be high at any time, and event IDs may name a context in any state. The design must ignore events that do not fit the target's state, so the stimulus deliberately sends fills, returns and park events to contexts in every state, including returns with the wrong ID. Halts are kept to the final phase so that the long random phase keeps enough contexts in the rotation. That phase sends random misses, fills and transplants against a randomly stalling helper. A drain phase and a single-survivor phase then force bubbles and the 14-cycle spacing limit.

// File: rtl/ctx_sched.sv
module ctx_sched #(
  parameter int NCTX = 16,
  parameter int PC_W = 32,
  parameter int DEPTH = 14,
  parameter logic [31:0] BOOT_PC = 32'h0000_1000,
  parameter logic [31:0] BOOT_STRIDE = 32'h0000_0100,
  parameter int INSN_BYTES = 4,
  localparam int ID_W = $clog2(NCTX),
  localparam int CW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              iss_valid,
  output logic [ID_W-1:0]   iss_ctx,
  output logic [PC_W-1:0]   iss_pc,
  input  logic              miss_valid,
  input  logic [ID_W-1:0]   miss_ctx,
  input  logic [PC_W-1:0]   miss_pc,
  input  logic              fill_valid,
  input  logic [ID_W-1:0]   fill_ctx,
  input  logic              unimp_valid,
  input  logic [ID_W-1:0]   unimp_ctx,
  input  logic [PC_W-1:0]   unimp_pc,
  input  logic              halt_valid,
  input  logic [ID_W-1:0]   halt_ctx,
  output logic              hoff_valid,
  input  logic              hoff_ready,
  output logic [ID_W-1:0]   hoff_ctx,
  output logic [PC_W-1:0]   hoff_pc,
  input  logic              hret_valid,
  input  logic [ID_W-1:0]   hret_ctx,
  input  logic [PC_W-1:0]   hret_pc,
  output logic [2*NCTX-1:0] ctx_state
);

  localparam logic [1:0] ST_RDY = 2'b00, ST_WAIT = 2'b01, ST_XPL = 2'b10, ST_HALT = 2'b11;
  localparam logic [1:0] H_IDLE = 2'd0, H_OFFER = 2'd1, H_BUSY = 2'd2;

  logic [1:0]      st   [NCTX];
  logic [PC_W-1:0] pc   [NCTX];
  logic [CW-1:0]   cool [NCTX];
  logic [ID_W-1:0] ptr, sel, hctx, pend_id;
  logic [1:0]      hs;
  logic            found, pend_any;

  always_comb begin
    found = 1'b0;
    sel = ptr;
    for (int k = NCTX - 1; k >= 0; k--) begin
      if (st[(int'(ptr) + k) % NCTX] == ST_RDY && cool[(int'(ptr) + k) % NCTX] == '0) begin
        found = 1'b1;
        sel = ID_W'((int'(ptr) + k) % NCTX);
      end
    end
  end

  always_comb begin
    pend_any = 1'b0;
    pend_id = '0;
    for (int i = NCTX - 1; i >= 0; i--) begin
      if (st[i] == ST_XPL) begin
        pend_any = 1'b1;
        pend_id = ID_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCTX; i++) begin
        st[i]   <= ST_RDY;
        pc[i]   <= PC_W'(BOOT_PC + BOOT_STRIDE * 32'(i));
        cool[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NCTX; i++) begin
        if (found && sel == ID_W'(i)) begin
          cool[i] <= CW'(DEPTH - 1);
          pc[i]   <= pc[i] + PC_W'(INSN_BYTES);
        end else if (cool[i] != '0) begin
          cool[i] <= cool[i] - 1'b1;
        end
        case (st[i])
          ST_RDY: begin
            if (halt_valid && halt_ctx == ID_W'(i)) begin
              st[i] <= ST_HALT;
            end else if (unimp_valid && unimp_ctx == ID_W'(i)) begin
              st[i] <= ST_XPL;
              pc[i] <= unimp_pc;
            end else if (miss_valid && miss_ctx == ID_W'(i)) begin
              st[i] <= ST_WAIT;
              pc[i] <= miss_pc;
            end
          end
          ST_WAIT: if (fill_valid && fill_ctx == ID_W'(i)) st[i] <= ST_RDY;
          ST_XPL: begin
            if (hs == H_BUSY && hctx == ID_W'(i) && hret_valid && hret_ctx == ID_W'(i)) begin
              st[i] <= ST_RDY;
              pc[i] <= hret_pc;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      iss_valid <= 1'b0;
      iss_ctx   <= '0;
      iss_pc    <= '0;
    end else begin
      iss_valid <= found;
      iss_ctx   <= sel;
      iss_pc    <= pc[sel];
      if (found) ptr <= ID_W'((int'(sel) + 1) % NCTX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs   <= H_IDLE;
      hctx <= '0;
    end else begin
      case (hs)
        H_IDLE:  if (pend_any) begin hs <= H_OFFER; hctx <= pend_id; end
        H_OFFER: if (hoff_ready) hs <= H_BUSY;
        default: if (hret_valid && hret_ctx == hctx) hs <= H_IDLE;
      endcase
    end
  end

  assign hoff_valid = (hs == H_OFFER);
  assign hoff_ctx   = hctx;
  assign hoff_pc    = pc[hctx];

  for (genvar g = 0; g < NCTX; g++) begin : g_state
    assign ctx_state[2*g +: 2] = st[g];
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      st[g] == ST_HALT |=> st[g] == ST_HALT); // R8
  end

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && $past(iss_valid) |-> iss_ctx != $past(iss_ctx)); // R3
  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hoff_valid && !hoff_ready |=> hoff_valid && $stable(hoff_ctx) && $stable(hoff_pc)); // R6
  AST_BUSY_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    hs == H_BUSY |-> st[hctx] == ST_XPL); // R7
  AST_FILL_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && st[fill_ctx] == ST_WAIT |=> st[$past(fill_ctx)] == ST_RDY); // R5

endmodule

// File: tb/ctx_sched_bench.sv
module ctx_sched_bench;
  localparam int N = 16;
  localparam int DEPTH = 14;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic iss_valid; logic [3:0] iss_ctx; logic [31:0] iss_pc;
  logic miss_valid = 0; logic [3:0] miss_ctx = 0; logic [31:0] miss_pc = 0;
  logic fill_valid = 0; logic [3:0] fill_ctx = 0;
  logic unimp_valid = 0; logic [3:0] unimp_ctx = 0; logic [31:0] unimp_pc = 0;
  logic halt_valid = 0; logic [3:0] halt_ctx = 0;
  logic hoff_valid; logic hoff_ready = 0; logic [3:0] hoff_ctx; logic [31:0] hoff_pc;
  logic hret_valid = 0; logic [3:0] hret_ctx = 0; logic [31:0] hret_pc = 0;
  logic [31:0] ctx_state;

  ctx_sched u_ctx_sched (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ctx(iss_ctx), .iss_pc(iss_pc),
    .miss_valid(miss_valid), .miss_ctx(miss_ctx), .miss_pc(miss_pc),
    .fill_valid(fill_valid), .fill_ctx(fill_ctx),
    .unimp_valid(unimp_valid), .unimp_ctx(unimp_ctx), .unimp_pc(unimp_pc),
    .halt_valid(halt_valid), .halt_ctx(halt_ctx),
    .hoff_valid(hoff_valid), .hoff_ready(hoff_ready), .hoff_ctx(hoff_ctx), .hoff_pc(hoff_pc),
    .hret_valid(hret_valid), .hret_ctx(hret_ctx), .hret_pc(hret_pc),
    .ctx_state(ctx_state)
  );

  int checks = 0, fails = 0, cyc = 0;
  string req = "R1";

  int m_st [N]; logic [31:0] m_pc [N]; int m_cool [N]; int m_last [N];
  int m_ptr, m_hs, m_hctx; bit m_iv; int m_ic; logic [31:0] m_ipc;

  task automatic check(bit ok, string r, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", r, what, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_st[i] = 0; m_pc[i] = 32'h1000 + 32'h100 * i; m_cool[i] = 0; m_last[i] = -1000;
    end
    m_ptr = 0; m_hs = 0; m_hctx = 0; m_iv = 0; m_ic = 0; m_ipc = 0;
  endtask

  task automatic model_edge();
    int sel, pend;
    int n_st [N]; logic [31:0] n_pc [N]; int n_cool [N];
    sel = -1; pend = -1;
    for (int k = 0; k < N; k++)
      if (sel < 0 && m_st[(m_ptr + k) % N] == 0 && m_cool[(m_ptr + k) % N] == 0) sel = (m_ptr + k) % N;
    for (int i = N - 1; i >= 0; i--) if (m_st[i] == 2) pend = i;
    for (int i = 0; i < N; i++) begin
      n_st[i] = m_st[i]; n_pc[i] = m_pc[i];
      n_cool[i] = (m_cool[i] > 0) ? m_cool[i] - 1 : 0;
      if (i == sel) begin n_cool[i] = DEPTH - 1; n_pc[i] = m_pc[i] + 4; end
      if (m_st[i] == 0) begin
        if (halt_valid && halt_ctx == i) n_st[i] = 3;
        else if (unimp_valid && unimp_ctx == i) begin n_st[i] = 2; n_pc[i] = unimp_pc; end
        else if (miss_valid && miss_ctx == i) begin n_st[i] = 1; n_pc[i] = miss_pc; end
      end else if (m_st[i] == 1) begin
        if (fill_valid && fill_ctx == i) n_st[i] = 0;
      end else if (m_st[i] == 2) begin
        if (m_hs == 2 && m_hctx == i && hret_valid && hret_ctx == i) begin n_st[i] = 0; n_pc[i] = hret_pc; end
      end
    end
    m_iv = (sel >= 0);
    if (sel >= 0) begin m_ic = sel; m_ipc = m_pc[sel]; m_ptr = (sel + 1) % N; end
    if (m_hs == 0) begin if (pend >= 0) begin m_hs = 1; m_hctx = pend; end end
    else if (m_hs == 1) begin if (hoff_ready) m_hs = 2; end
    else if (hret_valid && hret_ctx == m_hctx) m_hs = 0;
    for (int i = 0; i < N; i++) begin m_st[i] = n_st[i]; m_pc[i] = n_pc[i]; m_cool[i] = n_cool[i]; end
  endtask

  task automatic compare();
    check(iss_valid == m_iv, req, "iss_valid", iss_valid, m_iv);
    if (m_iv && iss_valid) begin
      check(iss_ctx == m_ic && iss_pc == m_ipc, req, "iss ctx/pc", {iss_ctx, iss_pc}, {m_ic[3:0], m_ipc});
      check(cyc - m_last[iss_ctx] >= DEPTH, "R3", "reissue gap", cyc - m_last[iss_ctx], DEPTH);
      m_last[iss_ctx] = cyc;
    end
    check(hoff_valid == (m_hs == 1), req, "hoff_valid", hoff_valid, m_hs == 1);
    if (m_hs == 1 && hoff_valid)
      check(hoff_ctx == m_hctx && hoff_pc == m_pc[m_hctx], req, "hoff ctx/pc",
            {hoff_ctx, hoff_pc}, {m_hctx[3:0], m_pc[m_hctx]});
    for (int i = 0; i < N; i++)
      if (ctx_state[2*i +: 2] != 2'(m_st[i]))
        check(0, req, $sformatf("ctx_state[%0d]", i), ctx_state[2*i +: 2], m_st[i]);
    checks++;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    cyc++;
    #1;
    compare();
    miss_valid = 0; fill_valid = 0; unimp_valid = 0; halt_valid = 0; hret_valid = 0;
  endtask

  task automatic ret_ok();
    hret_valid = 1; hret_ctx = 4'(m_hctx); hret_pc = 32'h8000 + 32'(m_hctx) * 16;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    req = "R1";
    compare();
    check(ctx_state == 32'h0, "R1", "ctx_state after reset", ctx_state, 0);
    rst_n = 1;

    req = "R2";
    repeat (20) step();

    req = "R4";
    miss_valid = 1; miss_ctx = 3; miss_pc = 32'h4440; step();
    check(ctx_state[7:6] == 2'b01, "R4", "ctx3 waiting", ctx_state[7:6], 1);
    repeat (20) step();
    req = "R5";
    fill_valid = 1; fill_ctx = 6; step();
    fill_valid = 1; fill_ctx = 3; step();
    check(ctx_state[7:6] == 2'b00, "R5", "ctx3 ready", ctx_state[7:6], 0);
    repeat (16) step();

    req = "R9";
    unimp_valid = 1; unimp_ctx = 4; unimp_pc = 32'h5550;
    miss_valid = 1; miss_ctx = 4; miss_pc = 32'h6660; step();
    check(ctx_state[9:8] == 2'b10, "R9", "unimp over miss", ctx_state[9:8], 2);
    req = "R6";
    unimp_valid = 1; unimp_ctx = 2; unimp_pc = 32'h2220; step();
    repeat (5) step();
    check(hoff_valid && hoff_ctx == 4 && hoff_pc == 32'h5550, "R6", "offer ctx4",
          {hoff_ctx, hoff_pc}, {4'd4, 32'h5550});
    hoff_ready = 1; step(); hoff_ready = 0;
    req = "R7";
    repeat (4) step();
    hret_valid = 1; hret_ctx = 2; hret_pc = 32'h1; step();
    check(!hoff_valid && ctx_state[5:4] == 2'b10, "R7", "wrong return ignored", ctx_state[5:4], 2);
    ret_ok(); step();
    repeat (3) step();
    check(hoff_valid && hoff_ctx == 2, "R7", "second offer after return", hoff_ctx, 2);
    hoff_ready = 1; step(); hoff_ready = 0;
    ret_ok(); step();
    repeat (4) step();

    req = "R2 R4 R5 R6 R7 R9 random";
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(3) == 0) begin miss_valid = 1; miss_ctx = 4'($urandom); miss_pc = $urandom & 32'hFFFC; end
      if ($urandom_range(2) == 0) begin fill_valid = 1; fill_ctx = 4'($urandom); end
      if ($urandom_range(7) == 0) begin unimp_valid = 1; unimp_ctx = 4'($urandom); unimp_pc = $urandom & 32'hFFFC; end
      hoff_ready = ($urandom_range(1) == 0);
      if (m_hs == 2 && $urandom_range(3) == 0) begin
        if ($urandom_range(4) == 0) begin hret_valid = 1; hret_ctx = 4'(m_hctx + 1); hret_pc = 0; end
        else ret_ok();
      end
      step();
    end

    req = "R5 R7 drain";
    hoff_ready = 1;
    for (int n = 0; n < 80; n++) begin
      for (int i = 0; i < N; i++) if (m_st[i] == 1) begin fill_valid = 1; fill_ctx = 4'(i); end
      if (m_hs == 2) ret_ok();
      step();
    end
    hoff_ready = 0;

    req = "R9 R8";
    halt_valid = 1; halt_ctx = 9; miss_valid = 1; miss_ctx = 9; miss_pc = 0; step();
    check(ctx_state[19:18] == 2'b11, "R9", "halt over miss", ctx_state[19:18], 3);
    for (int i = 0; i < N; i++) if (i != 7) begin halt_valid = 1; halt_ctx = 4'(i); step(); end
    req = "R3";
    fill_valid = 1; fill_ctx = 9; step();
    check(ctx_state[19:18] == 2'b11, "R8", "fill on halted ignored", ctx_state[19:18], 3);
    begin
      int issues = 0, bubbles = 0;
      for (int n = 0; n < 56; n++) begin
        step();
        if (iss_valid) begin
          issues++;
          check(iss_ctx == 7, "R3", "only survivor issues", iss_ctx, 7);
        end else bubbles++;
      end
      check(issues == 4 && bubbles == 52, "R3", "one issue per 14 cycles", issues, 4);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule